// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

A register-mapped timer that counts down from a software-supplied start value. The count advances on a tick taken from the input clock through a programmable prescaler: every clock, every 16 clocks or every 256 clocks. One 8-bit control word sets all of the following:
- whether the timer runs;
- whether the counter wraps to its maximum or reloads from the load register at zero;
- whether it stops after the first expiry;
- whether the counter is 16 or 32 bits wide;
- whether the interrupt reaches the output pin.

Software writes the registers through a simple single-cycle write port. Reads are combinational from the word address. Each count from 1 to 0 sets a sticky raw flag. The flag is visible on its own pin, and it drives the interrupt line when the interrupt is enabled. A write of any value to the clear location drops the flag.

Top module: `ptmr_timer`

## Requirements
- R1: Word offsets are: load at byte address 0x0, counter value at 0x4 (read/write), control at 0x8, interrupt clear at 0xC (write-only, reads 0). A load write sets both the load register and the counter. A value write sets only the counter.
- R2: Control bits 7:0 read back exactly as written, including reserved bit 4. Bits 31:8 of the control read as 0.
- R3: When control bit 7 is 0 the counter holds its value. Setting the bit again resumes counting from that value.
- R4: Control bits 3:2 select the prescale ratio: 00 = 1, 01 = 16, 10 = 256, 11 = 256. While enabled, the counter drops by one once per that many clocks.
- R5: A load write restarts the prescaler from zero. A value write leaves the prescaler phase unchanged.
- R6: With control bit 6 = 0 (free-running) and bit 0 = 0, a tick at zero wraps the counter to 0xFFFF in 16-bit mode or to 0xFFFFFFFF in 32-bit mode.
- R7: With control bit 6 = 1 (periodic) and bit 0 = 0, a tick at zero reloads the counter from the load register.
- R8: With control bit 0 = 1 (one-shot), the counter stays at zero until software writes the load or value register.
- R9: Control bit 1 selects the size: 0 = 16-bit, 1 = 32-bit. In 16-bit mode the value register reads with bits 31:16 zero.
- R10: A tick that takes the counter from 1 to 0 sets the raw flag, shown on raw_irq_o. irq_o is high exactly when the raw flag is set and control bit 5 is 1.
- R11: A write to 0xC clears the raw flag.
- R12: After reset every register reads 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address; bits 1:0 ignored |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt: raw flag gated by the enable bit |
| raw_irq_o | output | 1 | Raw interrupt flag |

## Verification
The bench builds the block with its defaults: a 32-bit counter, a 16-bit narrow mode and prescaler stages of 4 and 8 bits. The 4-bit and 8-bit stages give the divide-by-16 and divide-by-256 ratios. With these values the /256 boundary is reached in a few hundred cycles, and the 16-bit wrap to 0xFFFF is reachable from a small load value. The /16 stage also makes the prescaler phase observable. The bench therefore tells a load write, which restarts the phase, from a value write, which does not, by the cycle in which the next decrement lands.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam int unsigned CTRL_W = 8;

  typedef enum logic [1:0] {
    PRE_DIV1   = 2'b00,
    PRE_DIV16  = 2'b01,
    PRE_DIV256 = 2'b10,
    PRE_RSVD   = 2'b11
  } presc_e;

  // bit order matches the control word layout 7..0
  typedef struct packed {
    logic   en;
    logic   periodic;
    logic   irq_en;
    logic   spare;
    presc_e presc;
    logic   size32;
    logic   oneshot;
  } ctrl_t;

  // word indices (byte address >> 2)
  localparam logic [1:0] IDX_LOAD  = 2'd0;
  localparam logic [1:0] IDX_VALUE = 2'd1;
  localparam logic [1:0] IDX_CTRL  = 2'd2;
  localparam logic [1:0] IDX_ICLR  = 2'd3;
endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] load_o,
  output logic              load_wr_o,
  output logic              value_wr_o,
  output logic              iclr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [ADDR_W-1:0] word_idx;
  logic              hit_load, hit_value, hit_ctrl, hit_iclr;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] load_q;

  assign word_idx  = addr_i >> 2;
  assign hit_load  = (word_idx == ADDR_W'(IDX_LOAD));
  assign hit_value = (word_idx == ADDR_W'(IDX_VALUE));
  assign hit_ctrl  = (word_idx == ADDR_W'(IDX_CTRL));
  assign hit_iclr  = (word_idx == ADDR_W'(IDX_ICLR));

  assign load_wr_o  = wr_en_i && hit_load;
  assign value_wr_o = wr_en_i && hit_value;
  assign iclr_o     = wr_en_i && hit_iclr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else begin
      if (wr_en_i && hit_ctrl) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (load_wr_o)           load_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_load)       rdata_o = load_q;
    else if (hit_value) rdata_o = cnt_i;
    else if (hit_ctrl)  rdata_o = DATA_W'(ctrl_q);
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;

  // R2
  ctrl_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && hit_ctrl |=> ctrl_q == ctrl_t'($past(wdata_i[CTRL_W-1:0])));
endmodule

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
  import ptmr_pkg::*;
#(
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   en_i,
  input  logic   restart_i,
  input  presc_e sel_i,
  output logic   tick_o
);
  localparam int unsigned PW = HI_LOG2;
  localparam logic [PW-1:0] MID_MASK = PW'((1 << MID_LOG2) - 1);

  logic [PW-1:0] pcnt_q;
  logic [PW-1:0] mask;

  always_comb begin
    unique case (sel_i)
      PRE_DIV1:  mask = '0;
      PRE_DIV16: mask = MID_MASK;
      default:   mask = '1;  // 10 and reserved 11
    endcase
  end

  assign tick_o = en_i && ((pcnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pcnt_q <= '0;
    else if (restart_i) pcnt_q <= '0;
    else if (en_i)      pcnt_q <= pcnt_q + PW'(1);
  end

  // R4
  presc_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && sel_i != PRE_DIV1 && !restart_i |=> !tick_o || sel_i == PRE_DIV1);
endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ctrl_t             ctrl_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              load_wr_i,
  input  logic              value_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              iclr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              raw_o
);
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'({NARROW_W{1'b1}});

  logic [DATA_W-1:0] cnt_q, cnt_d, cnt_m, size_mask;
  logic              raw_q, hit, sw_wr;

  assign size_mask = ctrl_i.size32 ? '1 : NARROW_MASK;
  assign cnt_m     = cnt_q & size_mask;
  assign sw_wr     = load_wr_i || value_wr_i;

  always_comb begin
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (sw_wr) begin
      cnt_d = wdata_i;
    end else if (tick_i) begin
      if (cnt_m == '0) begin
        if (!ctrl_i.oneshot)
          cnt_d = ctrl_i.periodic ? (load_i & size_mask) : size_mask;
      end else begin
        cnt_d = cnt_m - DATA_W'(1);
        hit   = (cnt_m == DATA_W'(1));
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (hit)         raw_q <= 1'b1;
      else if (iclr_i) raw_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_m;
  assign raw_o = raw_q;

  // R3
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.en && !sw_wr |=> $stable(cnt_q));
  // R6
  free_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !ctrl_i.periodic && !ctrl_i.oneshot && cnt_m == '0 && !sw_wr
    |=> cnt_q == $past(size_mask));
  // R7
  periodic_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && ctrl_i.periodic && !ctrl_i.oneshot && cnt_m == '0 && !sw_wr
    |=> cnt_q == $past(load_i & size_mask));
  // R8
  oneshot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.oneshot && cnt_m == '0 && !sw_wr |=> cnt_q == $past(cnt_q));
  // R10
  raw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(raw_q) |-> $past(cnt_m) == DATA_W'(1) && $past(tick_i));
  // R11
  iclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iclr_i && !hit |=> !raw_q);
endmodule

// File: rtl/ptmr_timer.sv
module ptmr_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned MID_LOG2 = 4,
  parameter int unsigned HI_LOG2  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              raw_irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] load, cnt;
  logic              load_wr, value_wr, iclr, tick, raw;

  ptmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .cnt_i      (cnt),
    .ctrl_o     (ctrl),
    .load_o     (load),
    .load_wr_o  (load_wr),
    .value_wr_o (value_wr),
    .iclr_o     (iclr),
    .rdata_o
  );

  ptmr_prescaler #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) i_presc (
    .clk_i, .rst_ni,
    .en_i      (ctrl.en),
    .restart_i (load_wr),
    .sel_i     (ctrl.presc),
    .tick_o    (tick)
  );

  ptmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_cnt (
    .clk_i, .rst_ni,
    .ctrl_i     (ctrl),
    .tick_i     (tick),
    .load_i     (load),
    .load_wr_i  (load_wr),
    .value_wr_i (value_wr),
    .wdata_i,
    .iclr_i     (iclr),
    .cnt_o      (cnt),
    .raw_o      (raw)
  );

  assign raw_irq_o = raw;
  assign irq_o     = raw && ctrl.irq_en;

  // R10
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> raw_irq_o);
endmodule

// File: tb/test_ptmr_timer.sv
module test_ptmr_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, raw_irq;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptmr_timer #(.DATA_W(32), .NARROW_W(16), .ADDR_W(4), .MID_LOG2(4), .HI_LOG2(8))
  i_ptmr_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .raw_irq_o(raw_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // disable, clear flag, load (restarts prescaler), then enable
  task automatic arm(input logic [7:0] ctrl, input logic [31:0] ld);
    wr(4'h8, {24'h0, ctrl & 8'h7F});
    wr(4'hC, 32'h0);
    wr(4'h0, ld);
    wr(4'h8, {24'h0, ctrl});
  endtask

  task automatic t_reset;
    rd_chk("R12 load", 4'h0, 32'h0);
    rd_chk("R12 value", 4'h4, 32'h0);
    rd_chk("R12 ctrl", 4'h8, 32'h0);
    chk("R12 irq", {31'h0, irq}, 32'h0);
    chk("R12 raw", {31'h0, raw_irq}, 32'h0);
  endtask

  task automatic t_map;
    wr(4'h0, 32'hCAFE_1234);
    rd_chk("R1 load readback", 4'h0, 32'hCAFE_1234);
    rd_chk("R9 narrow value", 4'h4, 32'h0000_1234);
    wr(4'h8, 32'hFFFF_FF5E);
    rd_chk("R2 ctrl readback", 4'h8, 32'h0000_005E);
    rd_chk("R1 value via load", 4'h4, 32'hCAFE_1234);
    wr(4'h4, 32'h00AB_CDEF);
    rd_chk("R1 value write", 4'h4, 32'h00AB_CDEF);
    rd_chk("R1 load untouched", 4'h0, 32'hCAFE_1234);
    wr(4'h8, 32'h0000_0010);
    rd_chk("R2 spare bit", 4'h8, 32'h0000_0010);
    rd_chk("R1 iclr reads 0", 4'hC, 32'h0);
  endtask

  task automatic t_size;
    wr(4'h8, 32'h0);
    wr(4'h4, 32'h1234_5678);
    rd_chk("R9 upper zero", 4'h4, 32'h0000_5678);
    wr(4'h8, 32'h2);
    rd_chk("R9 wide read", 4'h4, 32'h1234_5678);
  endtask

  task automatic t_div;
    arm(8'h82, 32'd100);
    step(7);
    rd_chk("R4 div1", 4'h4, 32'd93);
    arm(8'h86, 32'd10);
    step(15);
    rd_chk("R4 div16 before", 4'h4, 32'd10);
    step(1);
    rd_chk("R4 div16 edge", 4'h4, 32'd9);
    step(16);
    rd_chk("R4 div16 second", 4'h4, 32'd8);
    arm(8'h8A, 32'd10);
    step(255);
    rd_chk("R4 div256 before", 4'h4, 32'd10);
    step(1);
    rd_chk("R4 div256 edge", 4'h4, 32'd9);
    arm(8'h8E, 32'd10);
    step(255);
    rd_chk("R4 code11 before", 4'h4, 32'd10);
    step(1);
    rd_chk("R4 code11 edge", 4'h4, 32'd9);
  endtask

  task automatic t_restart;
    arm(8'h86, 32'd500);
    step(8);
    wr(4'h0, 32'd50);
    step(15);
    rd_chk("R5 load restart hold", 4'h4, 32'd50);
    step(1);
    rd_chk("R5 load restart tick", 4'h4, 32'd49);
    step(8);
    wr(4'h4, 32'd70);
    step(6);
    rd_chk("R5 value keeps phase hold", 4'h4, 32'd70);
    step(1);
    rd_chk("R5 value keeps phase tick", 4'h4, 32'd69);
  endtask

  task automatic t_freeze;
    arm(8'h82, 32'd100);
    step(5);
    rd_chk("R3 running", 4'h4, 32'd95);
    wr(4'h8, 32'h02);
    step(10);
    rd_chk("R3 frozen", 4'h4, 32'd94);
    wr(4'h8, 32'h82);
    rd_chk("R3 kept", 4'h4, 32'd94);
    step(1);
    rd_chk("R3 resumed", 4'h4, 32'd93);
  endtask

  task automatic t_free;
    arm(8'h80, 32'd2);
    step(2);
    rd_chk("R6 at zero", 4'h4, 32'd0);
    step(1);
    rd_chk("R6 wrap16", 4'h4, 32'h0000_FFFF);
    step(1);
    rd_chk("R6 after wrap16", 4'h4, 32'h0000_FFFE);
    arm(8'h82, 32'd1);
    step(2);
    rd_chk("R6 wrap32", 4'h4, 32'hFFFF_FFFF);
  endtask

  task automatic t_periodic;
    arm(8'hC2, 32'd3);
    step(3);
    rd_chk("R7 at zero", 4'h4, 32'd0);
    chk("R10 raw on periodic expiry", {31'h0, raw_irq}, 32'd1);
    step(1);
    rd_chk("R7 reload", 4'h4, 32'd3);
    step(1);
    rd_chk("R7 after reload", 4'h4, 32'd2);
  endtask

  task automatic t_oneshot;
    arm(8'h83, 32'd2);
    step(2);
    rd_chk("R8 reach zero", 4'h4, 32'd0);
    step(5);
    rd_chk("R8 halted", 4'h4, 32'd0);
    chk("R10 raw one-shot", {31'h0, raw_irq}, 32'd1);
    wr(4'h0, 32'd4);
    rd_chk("R8 reloaded", 4'h4, 32'd4);
    step(1);
    rd_chk("R8 counts again", 4'h4, 32'd3);
  endtask

  task automatic t_irq;
    arm(8'hA2, 32'd2);
    step(1);
    chk("R10 no raw at 1", {31'h0, raw_irq}, 32'd0);
    chk("R10 no irq at 1", {31'h0, irq}, 32'd0);
    step(1);
    chk("R10 raw set", {31'h0, raw_irq}, 32'd1);
    chk("R10 irq set", {31'h0, irq}, 32'd1);
    wr(4'h8, 32'h82);
    chk("R10 irq masked", {31'h0, irq}, 32'd0);
    chk("R10 raw kept", {31'h0, raw_irq}, 32'd1);
    wr(4'h8, 32'hA2);
    chk("R10 irq unmasked", {31'h0, irq}, 32'd1);
    wr(4'hC, 32'h1234);
    chk("R11 raw cleared", {31'h0, raw_irq}, 32'd0);
    chk("R11 irq cleared", {31'h0, irq}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_map();
    t_size();
    t_div();
    t_restart();
    t_freeze();
    t_free();
    t_periodic();
    t_oneshot();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule